// File: doc/BRIEF.md
# Slot Reconfiguration Sequencer

This block runs the control sequence that brings a requested function module into one of a small set of reconfigurable slots. It owns a slot table recording which module sits in each slot. A request that names a module already resident finishes at once. Otherwise the sequencer takes the lowest empty slot. If every slot is occupied, it asks the bus arbiter which resident modules are currently inactive and evicts one of them.

For an eviction, the victim's table entry is withdrawn first, so that message routing, which reads the slot table, stops delivering to that slot. The victim's context words are then captured into a per-module store. The sequencer next issues the new module's bitstream address range to the configuration-port controller and waits for its done pulse. After that it replays the new module's saved context with an alternating sync bit. The new module is entered in the table as the last step. If the done pulse does not arrive within a run-time programmable number of cycles, the sequencer reports an error and leaves the slot empty.

The configuration-port controller, the arbiter and the modules' context interfaces all sit outside the block and are reached through simple pulse and valid handshakes.

Top module: `slot_reconfig_seq`

## Requirements
- R1: After reset no slot is occupied, `seq_busy` is 0, `req_ready` is 1 and neither `load_done` nor `err` is asserted.
- R2: A request is taken only while `req_ready` is 1. `seq_busy` stays 1 from the cycle after acceptance until the sequence ends. A request held on `req_valid` while busy is never taken: it starts no sequence and loads nothing.
- R3: A request for a module that is already resident ends with `load_done` and `target_slot` set to that slot. It issues no arbiter query and no configuration command.
- R4: When at least one slot is empty, the lowest-numbered empty slot is loaded. No arbiter query and no context save take place.
- R5: When every slot is occupied, `idle_query` is pulsed and the victim is taken only from the slots that the arbiter's `idle_mask` marks (bit i = slot i). A response with no usable bit causes a new query, so busy modules are never evicted.
- R6: Among the usable idle slots, the victim is the lowest-numbered slot whose recorded predecessor differs from the requested module. If every usable idle slot records the requested module as its predecessor, the lowest-numbered usable idle slot is taken.
- R7: The victim's `slot_valid` bit is 0 from the `save_req` cycle onward. The target slot is never marked valid while the configuration command is issued.
- R8: On `save_req`, exactly CTX_WORDS words on `save_valid`/`save_word` are stored for the evicted module. The configuration command follows only after the last word.
- R9: The configuration command pulses `cfg_start` with start address BS_BASE + module × BS_SPAN and end address start + BS_SPAN − 1.
- R10: After `cfg_done`, CTX_WORDS words come out on `restore_valid` in saved order. A module that has never been saved receives zeros. `restore_sync` is 1 on the first word and toggles on each further word.
- R11: The sequence completes with a one-cycle `load_done`, with `target_slot` naming the loaded slot and the slot table showing the new module valid there.
- R12: If `cfg_done` is missing, `err` pulses exactly `cfg_timeout` + 2 cycles after the `cfg_start` cycle. The target slot stays unassigned and the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_mod | input | MOD_W | Requested module id |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| seq_busy | output | 1 | Sequence in progress |
| slot_valid | output | NUM_SLOTS | Slot occupied and deliverable |
| slot_mod | output | NUM_SLOTS×MOD_W | Module id per slot, slot i at bits [i×MOD_W +: MOD_W] |
| idle_query | output | 1 | Ask arbiter for inactive modules |
| idle_resp_valid | input | 1 | Arbiter response present |
| idle_mask | input | NUM_SLOTS | Bit i set: module in slot i is inactive |
| target_slot | output | SLOT_W | Slot being saved, configured or restored |
| save_req | output | 1 | Start context save of target slot |
| save_valid | input | 1 | Context word from module valid |
| save_word | input | CTX_W | Context word from module |
| cfg_timeout | input | TMO_W | Cycles to wait for configuration done |
| cfg_start | output | 1 | Load command to configuration controller |
| cfg_start_addr | output | FA_W | Bitstream first address |
| cfg_end_addr | output | FA_W | Bitstream last address |
| cfg_done | input | 1 | Configuration finished |
| restore_valid | output | 1 | Context word to module valid |
| restore_word | output | CTX_W | Context word to module |
| restore_sync | output | 1 | Alternating word marker |
| load_done | output | 1 | Sequence completed |
| err | output | 1 | Configuration timed out |

## Verification
The bound checker watches every cycle for the following:
- a victim is never offered for save before its table entry is withdrawn;
- every victim comes from an arbiter response that marked it inactive;
- the target slot is never valid while the load command or the timeout error is raised;
- the command pulses never overlap;
- the restore sync bit alternates.

Which slot is picked under the predecessor rule, and its fallback, can only be shown by the bench's scenarios. The same holds for the exact address arithmetic, the round trip of saved context into a later restore, the zero fill for modules never saved, the re-query while every module is busy, and the exact timeout latency.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_LOOKUP, S_QUERY, S_WAIT_IDLE, S_SAVE_REQ,
    S_SAVE_WAIT, S_CFG, S_CFG_WAIT, S_RESTORE, S_COMMIT
  } seq_state_t;
endpackage

// File: rtl/rsq_slot_table.sv
module rsq_slot_table #(
  parameter int NUM_SLOTS = 4,
  parameter int MOD_W = 3,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_en,
  input  logic [SLOT_W-1:0] clr_slot,
  input  logic set_en,
  input  logic [SLOT_W-1:0] set_slot,
  input  logic [MOD_W-1:0] set_mod,
  input  logic set_pv,
  input  logic [MOD_W-1:0] set_pred,
  input  logic [MOD_W-1:0] look_mod,
  output logic [NUM_SLOTS-1:0] valid_o,
  output logic [NUM_SLOTS-1:0][MOD_W-1:0] mod_o,
  output logic [NUM_SLOTS-1:0] pv_o,
  output logic [NUM_SLOTS-1:0][MOD_W-1:0] pred_o,
  output logic free_any,
  output logic [SLOT_W-1:0] free_idx,
  output logic hit_any,
  output logic [SLOT_W-1:0] hit_idx
);
  // occupant field doubles as the "last loaded" history of each slot
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= '0;
      mod_o   <= '0;
      pv_o    <= '0;
      pred_o  <= '0;
    end else begin
      if (clr_en) valid_o[clr_slot] <= 1'b0;
      if (set_en) begin
        valid_o[set_slot] <= 1'b1;
        mod_o[set_slot]   <= set_mod;
        pv_o[set_slot]    <= set_pv;
        pred_o[set_slot]  <= set_pred;
      end
    end
  end

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    hit_any  = 1'b0;
    hit_idx  = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!valid_o[i]) begin
        free_any = 1'b1;
        free_idx = SLOT_W'(i);
      end
      if (valid_o[i] && (mod_o[i] == look_mod)) begin
        hit_any = 1'b1;
        hit_idx = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/rsq_victim_pick.sv
module rsq_victim_pick #(
  parameter int NUM_SLOTS = 4,
  parameter int MOD_W = 3,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0] idle_mask,
  input  logic [NUM_SLOTS-1:0] occ,
  input  logic [NUM_SLOTS-1:0] pv,
  input  logic [NUM_SLOTS-1:0][MOD_W-1:0] pred,
  input  logic [MOD_W-1:0] want,
  output logic found,
  output logic [SLOT_W-1:0] slot
);
  logic [NUM_SLOTS-1:0] cand;
  logic [NUM_SLOTS-1:0] pref;

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_cand
    assign cand[gi] = idle_mask[gi] & occ[gi];
    assign pref[gi] = cand[gi] & ~(pv[gi] && (pred[gi] == want));
  end

  always_comb begin
    found = |cand;
    slot  = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if ((|pref) ? pref[i] : cand[i]) slot = SLOT_W'(i);
    end
  end
endmodule

// File: rtl/rsq_ctx_store.sv
module rsq_ctx_store #(
  parameter int DEPTH = 160,
  parameter int DW = 10,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/slot_reconfig_seq.sv
module slot_reconfig_seq
  import rsq_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_MODS = 8,
  parameter int CTX_WORDS = 20,
  parameter int CTX_W = 10,
  parameter int FA_W = 24,
  parameter int TMO_W = 16,
  parameter logic [FA_W-1:0] BS_BASE = 24'h001000,
  parameter logic [FA_W-1:0] BS_SPAN = 24'h008000,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int MOD_W = (NUM_MODS > 1) ? $clog2(NUM_MODS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic [MOD_W-1:0] req_mod,
  output logic req_ready,
  output logic seq_busy,
  output logic [NUM_SLOTS-1:0] slot_valid,
  output logic [NUM_SLOTS*MOD_W-1:0] slot_mod,
  output logic idle_query,
  input  logic idle_resp_valid,
  input  logic [NUM_SLOTS-1:0] idle_mask,
  output logic [SLOT_W-1:0] target_slot,
  output logic save_req,
  input  logic save_valid,
  input  logic [CTX_W-1:0] save_word,
  input  logic [TMO_W-1:0] cfg_timeout,
  output logic cfg_start,
  output logic [FA_W-1:0] cfg_start_addr,
  output logic [FA_W-1:0] cfg_end_addr,
  input  logic cfg_done,
  output logic restore_valid,
  output logic [CTX_W-1:0] restore_word,
  output logic restore_sync,
  output logic load_done,
  output logic err
);
  localparam int DEPTH = NUM_MODS * CTX_WORDS;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CIW = (CTX_WORDS > 1) ? $clog2(CTX_WORDS) : 1;
  localparam logic [CIW-1:0] LAST_W = CIW'(CTX_WORDS - 1);

  seq_state_t state;
  logic [MOD_W-1:0] cur_mod, vic_mod;
  logic vic_has;
  logic [CIW-1:0] widx;
  logic [TMO_W-1:0] tcnt;
  logic [NUM_MODS-1:0] saved;
  logic rest_zero_q;
  logic [CTX_W-1:0] rd_word;

  logic [NUM_SLOTS-1:0][MOD_W-1:0] mod_tab, pred_tab;
  logic [NUM_SLOTS-1:0] pv_tab;
  logic free_any, hit_any, pick_found;
  logic [SLOT_W-1:0] free_idx, hit_idx, pick_slot;
  logic clr_en;

  assign clr_en = (state == S_WAIT_IDLE) && idle_resp_valid && pick_found;

  rsq_slot_table #(.NUM_SLOTS(NUM_SLOTS), .MOD_W(MOD_W)) u_table (
    .clk(clk), .rst(rst),
    .clr_en(clr_en), .clr_slot(pick_slot),
    .set_en(state == S_COMMIT), .set_slot(target_slot), .set_mod(cur_mod),
    .set_pv(vic_has), .set_pred(vic_mod),
    .look_mod(cur_mod),
    .valid_o(slot_valid), .mod_o(mod_tab), .pv_o(pv_tab), .pred_o(pred_tab),
    .free_any(free_any), .free_idx(free_idx), .hit_any(hit_any), .hit_idx(hit_idx)
  );

  rsq_victim_pick #(.NUM_SLOTS(NUM_SLOTS), .MOD_W(MOD_W)) u_pick (
    .idle_mask(idle_mask), .occ(slot_valid), .pv(pv_tab), .pred(pred_tab),
    .want(cur_mod), .found(pick_found), .slot(pick_slot)
  );

  rsq_ctx_store #(.DEPTH(DEPTH), .DW(CTX_W)) u_ctx (
    .clk(clk),
    .we((state == S_SAVE_WAIT) && save_valid),
    .waddr(AW'(vic_mod) * AW'(CTX_WORDS) + AW'(widx)),
    .wdata(save_word),
    .raddr(AW'(cur_mod) * AW'(CTX_WORDS) + AW'(widx)),
    .rdata(rd_word)
  );

  assign slot_mod       = mod_tab;
  assign req_ready      = (state == S_IDLE);
  assign seq_busy       = (state != S_IDLE);
  assign idle_query     = (state == S_QUERY);
  assign save_req       = (state == S_SAVE_REQ);
  assign cfg_start      = (state == S_CFG);
  assign cfg_start_addr = BS_BASE + FA_W'(cur_mod) * BS_SPAN;
  assign cfg_end_addr   = cfg_start_addr + BS_SPAN - FA_W'(1);
  assign restore_word   = rest_zero_q ? '0 : rd_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      cur_mod       <= '0;
      vic_mod       <= '0;
      vic_has       <= 1'b0;
      target_slot   <= '0;
      widx          <= '0;
      tcnt          <= '0;
      saved         <= '0;
      rest_zero_q   <= 1'b1;
      restore_valid <= 1'b0;
      restore_sync  <= 1'b0;
      load_done     <= 1'b0;
      err           <= 1'b0;
    end else begin
      load_done     <= 1'b0;
      err           <= 1'b0;
      restore_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          cur_mod <= req_mod;
          state   <= S_LOOKUP;
        end
        S_LOOKUP: begin
          if (hit_any) begin
            target_slot <= hit_idx;
            load_done   <= 1'b1;
            state       <= S_IDLE;
          end else if (free_any) begin
            target_slot <= free_idx;
            vic_has     <= 1'b0;
            state       <= S_CFG;
          end else begin
            state <= S_QUERY;
          end
        end
        S_QUERY: state <= S_WAIT_IDLE;
        S_WAIT_IDLE: if (idle_resp_valid) begin
          if (pick_found) begin
            target_slot <= pick_slot;
            vic_has     <= 1'b1;
            vic_mod     <= mod_tab[pick_slot];
            state       <= S_SAVE_REQ;
          end else begin
            state <= S_QUERY;
          end
        end
        S_SAVE_REQ: begin
          widx  <= '0;
          state <= S_SAVE_WAIT;
        end
        S_SAVE_WAIT: if (save_valid) begin
          if (widx == LAST_W) begin
            saved[vic_mod] <= 1'b1;
            state          <= S_CFG;
          end else begin
            widx <= widx + 1'b1;
          end
        end
        S_CFG: begin
          tcnt         <= '0;
          restore_sync <= 1'b0;
          state        <= S_CFG_WAIT;
        end
        S_CFG_WAIT: begin
          if (cfg_done) begin
            widx        <= '0;
            rest_zero_q <= !saved[cur_mod];
            state       <= S_RESTORE;
          end else if (tcnt == cfg_timeout) begin
            err   <= 1'b1;
            state <= S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_RESTORE: begin
          restore_valid <= 1'b1;
          restore_sync  <= !restore_sync;
          if (widx == LAST_W) state <= S_COMMIT;
          else widx <= widx + 1'b1;
        end
        S_COMMIT: begin
          load_done <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int NUM_SLOTS = 4,
  parameter int FA_W = 24,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic seq_busy,
  input logic [NUM_SLOTS-1:0] slot_valid,
  input logic idle_query,
  input logic idle_resp_valid,
  input logic [NUM_SLOTS-1:0] idle_mask,
  input logic [SLOT_W-1:0] target_slot,
  input logic save_req,
  input logic cfg_start,
  input logic [FA_W-1:0] cfg_start_addr,
  input logic [FA_W-1:0] cfg_end_addr,
  input logic restore_valid,
  input logic restore_sync,
  input logic load_done,
  input logic err
);
  logic [NUM_SLOTS-1:0] sel_oh;
  assign sel_oh = NUM_SLOTS'(1) << target_slot;

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> seq_busy);

  assert_idle_victim_R5: assert property (@(posedge clk) disable iff (rst)
    save_req |-> ($past(idle_resp_valid) && |($past(idle_mask) & sel_oh)));

  assert_cleared_at_save_R7: assert property (@(posedge clk) disable iff (rst)
    save_req |-> !slot_valid[target_slot]);

  assert_cfg_target_empty_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_start |-> !slot_valid[target_slot]);

  assert_cmd_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({idle_query, save_req, cfg_start, restore_valid}));

  assert_addr_order_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_start |-> (cfg_end_addr > cfg_start_addr));

  assert_sync_toggle_R10: assert property (@(posedge clk) disable iff (rst)
    (restore_valid && $past(restore_valid)) |-> (restore_sync != $past(restore_sync)));

  assert_done_entered_R11: assert property (@(posedge clk) disable iff (rst)
    load_done |-> (!seq_busy && slot_valid[target_slot]));

  assert_timeout_unassigned_R12: assert property (@(posedge clk) disable iff (rst)
    err |-> (!slot_valid[target_slot] && !load_done && !seq_busy));
endmodule

bind slot_reconfig_seq rsq_checker #(.NUM_SLOTS(NUM_SLOTS), .FA_W(FA_W)) u_chk (.*);

// File: tb/slot_reconfig_seq_test.sv
module slot_reconfig_seq_test;
  localparam int NS = 4;
  localparam int MW = 3;
  localparam int CTX = 20;
  localparam int NV = 8;
  localparam int VM    [NV] = '{2, 5, 7, 1, 5, 3, 5, 2};
  localparam int VK    [NV] = '{0, 0, 0, 0, 1, 2, 2, 2};
  localparam int VMASK [NV] = '{0, 0, 0, 0, 0, 6, 3, 1};
  localparam int VSLOT [NV] = '{0, 1, 2, 3, 1, 1, 0, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [MW-1:0] req_mod = '0;
  logic req_ready, seq_busy;
  logic [NS-1:0] slot_valid;
  logic [NS*MW-1:0] slot_mod;
  logic idle_query;
  logic idle_resp_valid = 1'b0;
  logic [NS-1:0] idle_mask = '0;
  logic [1:0] target_slot;
  logic save_req;
  logic save_valid = 1'b0;
  logic [9:0] save_word = '0;
  logic [15:0] cfg_timeout = 16'd500;
  logic cfg_start;
  logic [23:0] cfg_start_addr, cfg_end_addr;
  logic cfg_done = 1'b0;
  logic restore_valid;
  logic [9:0] restore_word;
  logic restore_sync, load_done, err;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int owner [NS];
  bit bsaved [8];

  slot_reconfig_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mod(req_mod),
    .req_ready(req_ready), .seq_busy(seq_busy), .slot_valid(slot_valid),
    .slot_mod(slot_mod), .idle_query(idle_query), .idle_resp_valid(idle_resp_valid),
    .idle_mask(idle_mask), .target_slot(target_slot), .save_req(save_req),
    .save_valid(save_valid), .save_word(save_word), .cfg_timeout(cfg_timeout),
    .cfg_start(cfg_start), .cfg_start_addr(cfg_start_addr), .cfg_end_addr(cfg_end_addr),
    .cfg_done(cfg_done), .restore_valid(restore_valid), .restore_word(restore_word),
    .restore_sync(restore_sync), .load_done(load_done), .err(err)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] pat(input int m, input int k);
    return 10'((m * 37 + k * 5 + 1) & 1023);
  endfunction

  task automatic check_table(input string req);
    for (int s = 0; s < NS; s++) begin
      chk(slot_valid[s] == (owner[s] >= 0), req, int'(slot_valid[s]), int'(owner[s] >= 0));
      if (owner[s] >= 0)
        chk(int'(slot_mod[s*MW +: MW]) == owner[s], req, int'(slot_mod[s*MW +: MW]), owner[s]);
    end
  endtask

  // kind: 0 = empty slot, 1 = resident, 2 = eviction
  task automatic serve(input int mod, input int kind, input int mask, input int zeros,
                       input int exp_slot, input bit tmo, input bit stray);
    int q = 0;
    bit pend = 0;
    bit saving = 0;
    int sk = 0;
    int cd = 0;
    int rk = 0;
    int cfg_c = -1;
    int end_c = -1;
    bit seen_save = 0;
    bit busy_bad = 0;
    int vmod;
    logic [9:0] ew;
    logic [23:0] sa;
    vmod = (kind == 2) ? owner[exp_slot] : 0;
    cfg_timeout = tmo ? 16'd10 : 16'd500;
    @(negedge clk);
    req_valid = 1'b1;
    req_mod = MW'(mod);
    @(negedge clk);
    req_valid = stray;
    req_mod = stray ? MW'(0) : MW'(mod);
    for (int c = 0; c < 800 && end_c < 0; c++) begin
      if (c > 0) @(negedge clk);
      idle_resp_valid = 1'b0;
      save_valid = 1'b0;
      cfg_done = 1'b0;
      if (pend) begin
        idle_resp_valid = 1'b1;
        idle_mask = (q <= zeros) ? '0 : NS'(mask);
        pend = 0;
      end
      if (saving) begin
        save_valid = 1'b1;
        save_word = pat(vmod, sk);
        sk++;
        if (sk == CTX) saving = 0;
      end
      if (cd > 0) begin
        cd--;
        if (cd == 0) cfg_done = 1'b1;
      end
      if (idle_query) begin
        q++;
        pend = 1;
      end
      if (save_req) begin
        seen_save = 1;
        chk(int'(target_slot) == exp_slot, "R6 victim slot", int'(target_slot), exp_slot);
        chk(!slot_valid[exp_slot], "R7 entry cleared", int'(slot_valid[exp_slot]), 0);
        chk(q == zeros + 1, "R5 victim only after idle response", q, zeros + 1);
        saving = 1;
        sk = 0;
      end
      if (cfg_start) begin
        sa = 24'h001000 + 24'(mod) * 24'h008000;
        chk(cfg_start_addr == sa, "R9 start address", int'(cfg_start_addr), int'(sa));
        chk(cfg_end_addr == sa + 24'h007fff, "R9 end address", int'(cfg_end_addr), int'(sa + 24'h007fff));
        chk(int'(target_slot) == exp_slot, "R4 target slot", int'(target_slot), exp_slot);
        if (kind == 2) chk(seen_save && sk == CTX, "R8 save before command", sk, CTX);
        cfg_c = c;
        if (!tmo) cd = 3;
      end
      if (restore_valid) begin
        ew = bsaved[mod] ? pat(mod, rk) : 10'd0;
        chk(restore_word == ew, "R10 restore word", int'(restore_word), int'(ew));
        chk(restore_sync == (rk % 2 == 0), "R10 sync", int'(restore_sync), int'(rk % 2 == 0));
        rk++;
      end
      if (load_done || err) end_c = c;
      else if (!seq_busy || req_ready) busy_bad = 1;
    end
    req_valid = 1'b0;
    chk(!busy_bad, "R2 busy throughout", int'(busy_bad), 0);
    if (tmo) begin
      chk(err && !load_done, "R12 error raised", int'(err), 1);
      chk(end_c - cfg_c == 12, "R12 timeout latency", end_c - cfg_c, 12);
      chk(!slot_valid[exp_slot], "R12 slot unassigned", int'(slot_valid[exp_slot]), 0);
      owner[exp_slot] = -1;
      bsaved[vmod] = 1;
    end else begin
      chk(load_done && !err, "R11 done pulse", int'(load_done), 1);
      chk(int'(target_slot) == exp_slot, "R11 done slot", int'(target_slot), exp_slot);
      if (kind == 1) chk(q == 0 && cfg_c < 0, "R3 resident no action", q, 0);
      if (kind == 0) chk(q == 0 && !seen_save, "R4 no query for empty slot", q, 0);
      if (kind == 2) chk(q == zeros + 1, "R5 query count", q, zeros + 1);
      if (kind != 1) chk(rk == CTX, "R10 restore count", rk, CTX);
      owner[exp_slot] = mod;
      if (kind == 2) bsaved[vmod] = 1;
    end
    check_table("R11 slot table");
  endtask

  initial begin
    for (int s = 0; s < NS; s++) owner[s] = -1;
    for (int m = 0; m < 8; m++) bsaved[m] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(slot_valid == '0, "R1 slots empty", int'(slot_valid), 0);
    chk(!seq_busy && req_ready, "R1 idle", int'(seq_busy), 0);
    chk(!load_done && !err, "R1 no pulses", int'(load_done), 0);

    for (int v = 0; v < NV; v++)
      serve(VM[v], VK[v], VMASK[v], 0, VSLOT[v], 1'b0, 1'b0);

    // R5: two all-busy responses, stray request held on the port (R2)
    serve(6, 2, 8, 2, 3, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk(!seq_busy, "R2 stray request ignored", int'(seq_busy), 0);
    check_table("R2 nothing loaded by stray request");

    // R12 timeout, then the empty slot is reused (R4)
    serve(4, 2, 4, 0, 2, 1'b1, 1'b0);
    serve(0, 0, 0, 0, 2, 1'b0, 1'b0);
    serve(7, 2, 15, 0, 0, 1'b0, 1'b0);
    // R6: lowest idle slot records requested module as predecessor, so skipped
    serve(2, 2, 3, 0, 1, 1'b0, 1'b0);

    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(slot_valid == '0 && !seq_busy, "R1 reset clears table", int'(slot_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule